// File: doc/BRIEF.md
# Edge-Select Dual Input Capture

This block watches an external input pin and, on the edge type chosen by a two-bit mode field, stores the value of a free-running counter in one of two capture slots. Slots fill in order: the first edge lands in slot 1 and the next in slot 2. After that the block holds both values and ignores further edges until its fill count is emptied. A single-cycle capture event is raised after either the first or the second capture, as chosen by a select bit.

The pin is asynchronous to the block clock, so it passes through a two-stage synchronizer before edge detection. The fill count is emptied by a capture-status clear strobe, by a soft reset, or by a change of the mode field from "off" to any edge mode. The counter itself and any interrupt masking sit outside the block.

Top module: `edge_capture_unit`

## Requirements
- R1: A change of `pin_raw` that is set up before rising clock edge E0 is detected after two synchronizer stages. `count_in` as presented at edge E2 is stored, and the slot and `cap_event` both show the result after E2.
- R2: `edge_mode` encoding is 0 = off (no capture), 1 = rising edges only, 2 = falling edges only, 3 = both edges.
- R3: Captures fill slot 1 (`cap1`) first and slot 2 (`cap2`) second. With both slots filled, further edges change neither slot and raise no event.
- R4: While `pin_is_input` is 0, no edge is captured and no event is raised.
- R5: The previous-level register follows the synchronized pin every cycle, whether or not a capture is allowed. A level reached while captures were blocked therefore yields no capture once they are allowed again.
- R6: With `event_on_second` = 0, `cap_event` follows the capture into slot 1. With it at 1, `cap_event` follows the capture into slot 2 only.
- R7: A `status_clr` pulse empties the fill count, so the next capture goes to slot 1. An edge detected in the same cycle as the clear is not captured.
- R8: A change of `edge_mode` from 0 to a nonzero value empties the fill count.
- R9: `rst` and `soft_rst` both clear `cap1`, `cap2`, `cap_event` and the fill count.
- R10: `cap_event` is high for one cycle per qualifying capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of slots, fill count and event |
| pin_raw | input | 1 | Asynchronous external pin |
| count_in | input | 32 | Free-running counter value |
| edge_mode | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| pin_is_input | input | 1 | 1 when the pin is used as an input; captures allowed |
| event_on_second | input | 1 | 0: event on first capture, 1: event on second |
| status_clr | input | 1 | Capture-status clear strobe; empties the fill count |
| cap1 | output | 32 | First capture slot |
| cap2 | output | 32 | Second capture slot |
| cap_event | output | 1 | Single-cycle capture event |

## Verification
The counter input is stepped every cycle while a pin edge moves through the synchronizer. The stored value therefore shows the exact capture cycle and separates a correct latency from one that is a cycle early or late. Rising, falling and both-edge sequences are run in each mode, so that a wrong decode of the mode field leaves a slot written or untouched where it should not be. Edge trains that overrun both slots, clears that land in the detection cycle, off-to-on mode changes and direction switches show apart fill ordering, clear priority, re-arming and the always-updated previous level. Runs with the select bit at each value show whether the event follows the correct capture.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    // Edge qualification for one cycle given current and previous level
    function automatic logic edge_hit(edge_mode_e mode, logic lvl_now, logic lvl_prev);
        logic rise;
        logic fall;
        rise = lvl_now & ~lvl_prev;
        fall = ~lvl_now & lvl_prev;
        case (mode)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_raw};
        end
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
    import edge_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  edge_mode_e mode,
    output logic       hit
);
    logic prev_q;

    // previous level tracks the pin every cycle, captures allowed or not
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    assign hit = edge_hit(mode, lvl, prev_q);
endmodule

// File: rtl/cap_slot_store.sv
module cap_slot_store #(
    parameter int W     = 32,
    parameter int SLOTS = 2,
    localparam int IDX_W = $clog2(SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      soft_rst,
    input  logic                      hit,
    input  logic                      take_en,
    input  logic                      fill_clr,
    input  logic                      evt_late,
    input  logic [W-1:0]              count_in,
    output logic [SLOTS-1:0][W-1:0]   slots,
    output logic [IDX_W-1:0]          fill,
    output logic                      evt
);
    logic [IDX_W-1:0] fill_q;
    logic             evt_q;
    logic             take;

    assign take = hit && take_en && !fill_clr && (fill_q < IDX_W'(SLOTS));

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            fill_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            evt_q <= take && (fill_q == IDX_W'(evt_late));
            if (fill_clr) begin
                fill_q <= '0;
            end else if (take) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                val_q <= '0;
            end else if (take && (fill_q == IDX_W'(g))) begin
                val_q <= count_in;
            end
        end
        assign slots[g] = val_q;
    end

    assign fill = fill_q;
    assign evt  = evt_q;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import edge_cap_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_rst,
    input  logic         pin_raw,
    input  logic [W-1:0] count_in,
    input  logic [1:0]   edge_mode,
    input  logic         pin_is_input,
    input  logic         event_on_second,
    input  logic         status_clr,
    output logic [W-1:0] cap1,
    output logic [W-1:0] cap2,
    output logic         cap_event
);
    localparam int SLOTS = 2;
    localparam int IDX_W = $clog2(SLOTS + 1);

    edge_mode_e             mode_now;
    edge_mode_e             mode_q;
    logic                   pin_s;
    logic                   hit;
    logic                   rearm;
    logic [SLOTS-1:0][W-1:0] slot_vals;
    logic [IDX_W-1:0]       fill;

    assign mode_now = edge_mode_e'(edge_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= EDGE_OFF;
        end else begin
            mode_q <= mode_now;
        end
    end

    assign rearm = (mode_q == EDGE_OFF) && (mode_now != EDGE_OFF);

    cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_raw),
        .pin_sync (pin_s)
    );

    cap_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (pin_s),
        .mode (mode_now),
        .hit  (hit)
    );

    cap_slot_store #(.W(W), .SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .hit      (hit),
        .take_en  (pin_is_input),
        .fill_clr (status_clr | rearm),
        .evt_late (event_on_second),
        .count_in (count_in),
        .slots    (slot_vals),
        .fill     (fill),
        .evt      (cap_event)
    );

    assign cap1 = slot_vals[0];
    assign cap2 = slot_vals[1];
endmodule

// File: rtl/edge_capture_checks.sv
module edge_capture_checks #(
    parameter int W      = 32,
    parameter int FILL_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic [1:0]        edge_mode,
    input logic              pin_is_input,
    input logic              status_clr,
    input logic [W-1:0]      cap1,
    input logic [W-1:0]      cap2,
    input logic              cap_event,
    input logic [FILL_W-1:0] fill
);
    a_r3_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(2));

    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fill == FILL_W'(2) && !soft_rst) |=> ($stable(cap1) && $stable(cap2) && !cap_event));

    a_r4_output_dir_holds: assert property (@(posedge clk) disable iff (rst)
        (!pin_is_input && !soft_rst) |=> ($stable(cap1) && $stable(cap2) && !cap_event));

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (edge_mode == 2'd0) |=> !cap_event);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cap_event |=> !cap_event);

    a_r9_soft_clear: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cap1 == '0 && cap2 == '0 && !cap_event && fill == '0));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !soft_rst) |=> (fill == '0));
endmodule

bind edge_capture_unit edge_capture_checks #(.W(W), .FILL_W(IDX_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .edge_mode    (edge_mode),
    .pin_is_input (pin_is_input),
    .status_clr   (status_clr),
    .cap1         (cap1),
    .cap2         (cap2),
    .cap_event    (cap_event),
    .fill         (u_store.fill)
);

// File: tb/test_edge_capture_unit.sv
`timescale 1ns/1ps
module test_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        pin_raw = 1'b0;
    logic [31:0] count_in = '0;
    logic [1:0]  edge_mode = 2'd0;
    logic        pin_is_input = 1'b0;
    logic        event_on_second = 1'b0;
    logic        status_clr = 1'b0;
    logic [31:0] cap1;
    logic [31:0] cap2;
    logic        cap_event;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    edge_capture_unit i_edge_capture_unit (
        .clk             (clk),
        .rst             (rst),
        .soft_rst        (soft_rst),
        .pin_raw         (pin_raw),
        .count_in        (count_in),
        .edge_mode       (edge_mode),
        .pin_is_input    (pin_is_input),
        .event_on_second (event_on_second),
        .status_clr      (status_clr),
        .cap1            (cap1),
        .cap2            (cap2),
        .cap_event       (cap_event)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Drive a pin level with a stepping counter; returns at the sample point
    // just after the capturing edge (R1: count_in at E2 = base+2).
    task automatic edge_cap(input logic lvl, input logic [31:0] base, output logic ev);
        pin_raw  = lvl;
        count_in = base;
        @(negedge clk);
        count_in = base + 1;
        @(negedge clk);
        count_in = base + 2;
        @(negedge clk);
        ev = cap_event;
        count_in = base + 3;
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic dir, input logic late);
        edge_mode       = m;
        pin_is_input    = dir;
        event_on_second = late;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 reset cap1", cap1, 32'd0);
        check("R9 reset cap2", cap2, 32'd0);
        check("R9 reset event", {31'd0, cap_event}, 32'd0);
    endtask

    task automatic t_rise_order();
        logic ev;
        set_cfg(2'd1, 1'b1, 1'b1);
        edge_cap(1'b1, 32'd100, ev);
        check("R1 capture cycle value", cap1, 32'd102);
        check("R6 no event on first when late", {31'd0, ev}, 32'd0);
        edge_cap(1'b0, 32'd150, ev);
        check("R2 fall ignored in rise mode", cap2, 32'd0);
        edge_cap(1'b1, 32'd200, ev);
        check("R3 second goes to slot 2", cap2, 32'd202);
        check("R6 event on second capture", {31'd0, ev}, 32'd1);
        edge_cap(1'b0, 32'd250, ev);
        edge_cap(1'b1, 32'd300, ev);
        check("R3 full slot1 held", cap1, 32'd102);
        check("R3 full slot2 held", cap2, 32'd202);
        check("R3 full no event", {31'd0, ev}, 32'd0);
    endtask

    task automatic t_mode_rearm();
        logic ev;
        set_cfg(2'd0, 1'b1, 1'b1);
        set_cfg(2'd1, 1'b1, 1'b1);
        edge_cap(1'b0, 32'd350, ev);
        edge_cap(1'b1, 32'd400, ev);
        check("R8 rearm refills slot 1", cap1, 32'd402);
        check("R8 slot 2 untouched", cap2, 32'd202);
    endtask

    task automatic t_clr_priority();
        logic ev;
        edge_cap(1'b0, 32'd450, ev);
        pin_raw  = 1'b1;
        count_in = 32'd470;
        @(negedge clk);
        count_in = 32'd471;
        @(negedge clk);
        count_in   = 32'd472;
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        check("R7 edge with clear not captured", cap2, 32'd202);
        check("R7 no event with clear", {31'd0, cap_event}, 32'd0);
        edge_cap(1'b0, 32'd480, ev);
        edge_cap(1'b1, 32'd500, ev);
        check("R7 after clear slot 1 again", cap1, 32'd502);
    endtask

    task automatic t_clear_first_event();
        logic ev;
        pulse_clr();
        set_cfg(2'd1, 1'b1, 1'b0);
        edge_cap(1'b0, 32'd550, ev);
        edge_cap(1'b1, 32'd600, ev);
        check("R7 clear then capture slot 1", cap1, 32'd602);
        check("R6 event on first capture", {31'd0, ev}, 32'd1);
        @(negedge clk);
        check("R10 event lasts one cycle", {31'd0, cap_event}, 32'd0);
    endtask

    task automatic t_fall();
        logic ev;
        pulse_clr();
        set_cfg(2'd2, 1'b1, 1'b0);
        edge_cap(1'b0, 32'd700, ev);
        check("R2 fall mode captures fall", cap1, 32'd702);
        edge_cap(1'b1, 32'd750, ev);
        check("R2 fall mode ignores rise", cap2, 32'd202);
    endtask

    task automatic t_both();
        logic ev;
        pulse_clr();
        set_cfg(2'd3, 1'b1, 1'b0);
        edge_cap(1'b0, 32'd800, ev);
        check("R2 both mode fall", cap1, 32'd802);
        edge_cap(1'b1, 32'd900, ev);
        check("R2 both mode rise", cap2, 32'd902);
    endtask

    task automatic t_none();
        logic ev;
        set_cfg(2'd0, 1'b1, 1'b0);
        pulse_clr();
        edge_cap(1'b0, 32'd1000, ev);
        edge_cap(1'b1, 32'd1100, ev);
        check("R2 off mode slot1", cap1, 32'd802);
        check("R2 off mode slot2", cap2, 32'd902);
        check("R2 off mode no event", {31'd0, ev}, 32'd0);
    endtask

    task automatic t_direction();
        logic ev;
        set_cfg(2'd1, 1'b0, 1'b0);
        edge_cap(1'b0, 32'd1150, ev);
        edge_cap(1'b1, 32'd1200, ev);
        check("R4 output dir no capture", cap1, 32'd802);
        check("R4 output dir no event", {31'd0, ev}, 32'd0);
        set_cfg(2'd1, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R5 no late capture", cap1, 32'd802);
        check("R5 no late event", {31'd0, cap_event}, 32'd0);
        edge_cap(1'b0, 32'd1250, ev);
        edge_cap(1'b1, 32'd1300, ev);
        check("R4 input dir captures", cap1, 32'd1302);
    endtask

    task automatic t_soft();
        logic ev;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R9 soft clears slot 1", cap1, 32'd0);
        check("R9 soft clears slot 2", cap2, 32'd0);
        edge_cap(1'b0, 32'd1350, ev);
        edge_cap(1'b1, 32'd1400, ev);
        check("R9 soft empties fill", cap1, 32'd1402);
        check("R9 slot 2 still clear", cap2, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rise_order();
        t_mode_rearm();
        t_clr_priority();
        t_clear_first_event();
        t_fall();
        t_both();
        t_none();
        t_direction();
        t_soft();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule